// File: doc/BRIEF.md
# External Bus Strobe Generator

This block drives the two timing strobes of a multiplexed external memory bus: an active-high address-latch strobe, which tells external logic when to capture the low address byte, and an active-low program-read strobe, which gates external code memory onto the bus. The CPU sequencer supplies its machine-state count, which runs through twelve oscillator clocks per machine cycle. The block splits each machine cycle into two equal halves. It places one address-latch pulse at the start of each half. When code is fetched from external memory, it places one read window at the end of each half.

The sequencer also reports what the current machine cycle is doing: an external data move, an external code move, or anything else. During an external data move, the block drops the second address-latch pulse and both read windows, which frees the bus for the data transfer. A quiet-mode input keeps the address-latch line high and free of pulses, except during data or code moves. External-execution mode overrides quiet mode. Both outputs are registered, so each one reflects the inputs sampled at the previous clock edge.

Top module: `ext_bus_strobe_gen`

## Requirements
- R1: While `rst` is high, `ale` is 0 and `prog_rd_n` is 1 one clock later.
- R2: With `insn_class` = 2'b00 (other), `ale_quiet` = 0 and `mstate` below 12, `ale` is high one clock after `mstate` is 0, 1, 6 or 7, and low after every other state. This gives two 2-clock pulses per machine cycle, one sixth of the clock rate.
- R3: With `insn_class` = 2'b01 (external data move), the pulse for states 6 and 7 is omitted, and the pulse for states 0 and 1 is kept.
- R4: With `ext_exec` = 1 and a class other than 2'b01, `prog_rd_n` is low one clock after `mstate` is 3, 4, 5, 9, 10 or 11, and high after states 0, 1, 2, 6, 7 and 8.
- R5: With `ext_exec` = 0, `prog_rd_n` stays high for every state and class.
- R6: With `insn_class` = 2'b01, `prog_rd_n` stays high for every state, even with `ext_exec` = 1.
- R7: With `ale_quiet` = 1, `ext_exec` = 0 and `insn_class` = 2'b00 or 2'b11 (2'b11 is handled as other), `ale` is held high in every state, with no pulse.
- R8: With `ale_quiet` = 1 and `insn_class` = 2'b01 or 2'b10 (external code move), `ale` follows the pattern of R2, with the omission of R3 for 2'b01.
- R9: With `ext_exec` = 1, `ale_quiet` has no effect on `ale`.
- R10: An `mstate` value of 12 to 15 is outside the machine cycle. It produces no `ale` pulse and a high `prog_rd_n`, except that the held-high level of R7 still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| mstate | input | 4 | Machine-state count, 0 to 11 inside a machine cycle |
| ext_exec | input | 1 | Code is being executed from external program memory |
| insn_class | input | 2 | 00 other, 01 external data move, 10 external code move, 11 other |
| ale_quiet | input | 1 | Quiet mode for the address-latch strobe |
| ale | output | 1 | Address-latch strobe, active high, registered |
| prog_rd_n | output | 1 | Program-read strobe, active low, registered |

## Verification
The bench sweeps every state value under each combination of class, quiet mode and execution mode. It then runs random traffic against a bench model of the requirements. The first corner case is the data-move cycle. A design that skips the wrong half would lose the pulse that latches the data address. A design that keeps the read windows would collide with the data transfer. The second corner case is quiet mode. A design that ignores the external-execution override would starve external fetches of address latches. A design that silences code moves would break table reads. States 12 to 15 are also driven, to catch decoding that wraps or aliases into a pulse window.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [1:0] {
    CLS_OTHER = 2'b00,
    CLS_XDATA = 2'b01,
    CLS_XCODE = 2'b10,
    CLS_RSVD  = 2'b11
  } insn_class_e;
endpackage

// File: rtl/sg_phase_decode.sv
module sg_phase_decode #(
  parameter int CYCLE_LEN = 12,
  parameter int SLOTS     = 2,
  parameter int ALE_W     = 2,
  parameter int RD_START  = 3,
  localparam int PH_W     = $clog2(CYCLE_LEN),
  localparam int PW       = PH_W + 1,
  localparam int SLOT_LEN = CYCLE_LEN / SLOTS
) (
  input  logic [PH_W-1:0]  mstate,
  output logic [SLOTS-1:0] ale_win,
  output logic [SLOTS-1:0] rd_win
);
  logic [PW-1:0] ph_ext;
  assign ph_ext = {1'b0, mstate};

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam logic [PW-1:0] LO = PW'(s * SLOT_LEN);
    localparam logic [PW-1:0] HI = PW'((s + 1) * SLOT_LEN);
    logic          hit;
    logic [PW-1:0] off;
    assign hit        = (ph_ext >= LO) && (ph_ext < HI);
    assign off        = ph_ext - LO;
    assign ale_win[s] = hit && (off < PW'(ALE_W));
    assign rd_win[s]  = hit && (off >= PW'(RD_START));
  end
endmodule

// File: rtl/sg_addr_gate.sv
module sg_addr_gate
  import sg_pkg::*;
#(
  parameter int SLOTS     = 2,
  parameter int SKIP_SLOT = 1
) (
  input  logic [SLOTS-1:0] ale_win,
  input  insn_class_e      cls,
  input  logic             ext_exec,
  input  logic             ale_quiet,
  output logic             ale_next
);
  logic             is_data;
  logic             is_move;
  logic             held_high;
  logic [SLOTS-1:0] keep;

  assign is_data   = (cls == CLS_XDATA);
  assign is_move   = is_data || (cls == CLS_XCODE);
  assign held_high = ale_quiet && !ext_exec && !is_move;

  always_comb begin
    keep = '1;
    if (is_data) keep[SKIP_SLOT] = 1'b0;
  end

  assign ale_next = held_high || (|(ale_win & keep));
endmodule

// File: rtl/sg_read_gate.sv
module sg_read_gate
  import sg_pkg::*;
#(
  parameter int SLOTS = 2
) (
  input  logic [SLOTS-1:0] rd_win,
  input  insn_class_e      cls,
  input  logic             ext_exec,
  output logic             rd_next_n
);
  assign rd_next_n = !(ext_exec && (cls != CLS_XDATA) && (|rd_win));
endmodule

// File: rtl/ext_bus_strobe_gen.sv
module ext_bus_strobe_gen
  import sg_pkg::*;
#(
  parameter int CYCLE_LEN = 12,
  parameter int SLOTS     = 2,
  parameter int ALE_W     = 2,
  parameter int RD_START  = 3,
  localparam int PH_W     = $clog2(CYCLE_LEN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PH_W-1:0] mstate,
  input  logic            ext_exec,
  input  logic [1:0]      insn_class,
  input  logic            ale_quiet,
  output logic            ale,
  output logic            prog_rd_n
);
  logic [SLOTS-1:0] ale_win;
  logic [SLOTS-1:0] rd_win;
  logic             ale_next;
  logic             rd_next_n;
  insn_class_e      cls;

  assign cls = insn_class_e'(insn_class);

  sg_phase_decode #(
    .CYCLE_LEN(CYCLE_LEN), .SLOTS(SLOTS), .ALE_W(ALE_W), .RD_START(RD_START)
  ) u_dec (
    .mstate (mstate),
    .ale_win(ale_win),
    .rd_win (rd_win)
  );

  sg_addr_gate #(.SLOTS(SLOTS), .SKIP_SLOT(SLOTS - 1)) u_addr (
    .ale_win  (ale_win),
    .cls      (cls),
    .ext_exec (ext_exec),
    .ale_quiet(ale_quiet),
    .ale_next (ale_next)
  );

  sg_read_gate #(.SLOTS(SLOTS)) u_rd (
    .rd_win   (rd_win),
    .cls      (cls),
    .ext_exec (ext_exec),
    .rd_next_n(rd_next_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ale       <= 1'b0;
      prog_rd_n <= 1'b1;
    end else begin
      ale       <= ale_next;
      prog_rd_n <= rd_next_n;
    end
  end
endmodule

// File: rtl/sg_strobe_chk.sv
module sg_strobe_chk #(
  parameter int CYCLE_LEN = 12,
  parameter int SLOTS     = 2,
  parameter int ALE_W     = 2,
  parameter int RD_START  = 3,
  localparam int PH_W     = $clog2(CYCLE_LEN),
  localparam int SLOT_LEN = CYCLE_LEN / SLOTS
) (
  input logic            clk,
  input logic            rst,
  input logic [PH_W-1:0] mstate,
  input logic            ext_exec,
  input logic [1:0]      insn_class,
  input logic            ale_quiet,
  input logic            ale,
  input logic            prog_rd_n
);
  int unsigned ph;
  assign ph = 32'(mstate);

  // R5
  no_read_internal_chk: assert property (@(posedge clk) disable iff (rst)
    !ext_exec |=> prog_rd_n);

  // R6
  no_read_in_data_chk: assert property (@(posedge clk) disable iff (rst)
    (insn_class == 2'b01) |=> prog_rd_n);

  // R3
  data_skip_chk: assert property (@(posedge clk) disable iff (rst)
    ((insn_class == 2'b01) && (ph >= CYCLE_LEN - SLOT_LEN) && (ph < CYCLE_LEN)) |=> !ale);

  // R4
  read_window_chk: assert property (@(posedge clk) disable iff (rst)
    (ext_exec && (insn_class != 2'b01) && (ph < CYCLE_LEN) &&
     ((ph % SLOT_LEN) >= RD_START)) |=> !prog_rd_n);

  // R7
  quiet_high_chk: assert property (@(posedge clk) disable iff (rst)
    (ale_quiet && !ext_exec && insn_class[0] == insn_class[1]) |=> ale);

  // R10
  out_of_range_chk: assert property (@(posedge clk) disable iff (rst)
    ((ph >= CYCLE_LEN) && !ale_quiet) |=> (!ale && prog_rd_n));
endmodule

bind ext_bus_strobe_gen sg_strobe_chk #(
  .CYCLE_LEN(CYCLE_LEN), .SLOTS(SLOTS), .ALE_W(ALE_W), .RD_START(RD_START)
) u_chk (
  .clk(clk), .rst(rst), .mstate(mstate), .ext_exec(ext_exec),
  .insn_class(insn_class), .ale_quiet(ale_quiet), .ale(ale), .prog_rd_n(prog_rd_n)
);

// File: tb/tb_ext_bus_strobe_gen.sv
module tb_ext_bus_strobe_gen;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] mstate;
  logic       ext_exec;
  logic [1:0] insn_class;
  logic       ale_quiet;
  logic       ale;
  logic       prog_rd_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ext_bus_strobe_gen dut (
    .clk(clk), .rst(rst), .mstate(mstate), .ext_exec(ext_exec),
    .insn_class(insn_class), .ale_quiet(ale_quiet), .ale(ale), .prog_rd_n(prog_rd_n)
  );

  function automatic logic exp_ale(int ph, logic ex, logic [1:0] c, logic q);
    logic data, move;
    data = (c == 2'b01);
    move = data || (c == 2'b10);
    if (q && !ex && !move) return 1'b1;
    if (ph >= 12) return 1'b0;
    if (data && ph >= 6) return 1'b0;
    return ((ph % 6) < 2);
  endfunction

  function automatic logic exp_rd_n(int ph, logic ex, logic [1:0] c);
    if (ph >= 12 || !ex || c == 2'b01) return 1'b1;
    return !((ph % 6) >= 3);
  endfunction

  function automatic string tag(int ph, logic ex, logic [1:0] c, logic q);
    if (ph >= 12) return "R10";
    if (q && ex) return "R9";
    if (q && (c == 2'b00 || c == 2'b11)) return "R7";
    if (q) return "R8";
    if (c == 2'b01) return "R3/R6";
    if (!ex) return "R2/R5";
    return "R2/R4";
  endfunction

  task automatic step(int ph, logic ex, logic [1:0] c, logic q);
    logic ea, er;
    mstate = 4'(ph); ext_exec = ex; insn_class = c; ale_quiet = q;
    ea = exp_ale(ph, ex, c, q);
    er = exp_rd_n(ph, ex, c);
    @(negedge clk);
    checks++;
    if (ale !== ea || prog_rd_n !== er) begin
      errors++;
      $display("FAIL %s ph=%0d ex=%0b cls=%0d q=%0b: ale=%0b rd_n=%0b expected ale=%0b rd_n=%0b",
               tag(ph, ex, c, q), ph, ex, c, q, ale, prog_rd_n, ea, er);
    end
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    rst = 1'b1; mstate = 4'd0; ext_exec = 1'b1; insn_class = 2'b00; ale_quiet = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      mstate = 4'(i); ext_exec = 1'b1; ale_quiet = 1'(i & 1);
      @(negedge clk);
      checks++;
      if (ale !== 1'b0 || prog_rd_n !== 1'b1) begin
        errors++;
        $display("FAIL R1 reset: ale=%0b rd_n=%0b expected ale=0 rd_n=1", ale, prog_rd_n);
      end
    end
    rst = 1'b0;
    // Directed sweeps: every state under every mode combination (R2..R10)
    for (int q = 0; q < 2; q++)
      for (int ex = 0; ex < 2; ex++)
        for (int c = 0; c < 4; c++)
          for (int ph = 0; ph < 16; ph++)
            step(ph, 1'(ex), 2'(c), 1'(q));
    // Random traffic, mostly in-range states walking through cycles
    for (int n = 0; n < 3000; n++) begin
      int ph;
      ph = ($urandom % 8 == 0) ? int'($urandom % 16) : (n % 12);
      step(ph, 1'($urandom % 2), 2'($urandom % 4), 1'($urandom % 4 == 0));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule